// File: doc/BRIEF.md
# Programmable 16-bit up/down interval timer

This block is a small timer peripheral that a processor reaches through a 32-bit word-addressed register bus. Software chooses a counting direction and a power-of-two clock divider, loads a reload limit and an initial count, and then starts the counter with a command write. Each time the count wraps, the block raises a sticky event flag. The flags are gated by an enable mask onto one level-sensitive interrupt line.

The timer runs in two ways. In continuous operation it wraps and carries on from the reload limit (down) or from zero (up). In single-shot operation it halts itself on the first wrap. Software can then load a fresh count and restart it for the next event, which is how a tick-less event scheduler would use it. A second timer instance, left free-running upward, can serve as a monotonic time base.

Top module: `updn_timer`

## Requirements
- R1: After reset, the timer is stopped. The control word, the enable mask, the flags and the count read 0. The reload limit reads 0xFFFF. The interrupt output is low.
- R2: Word offsets are as follows: control 0x00, command 0x04, enable mask 0x0C, flags 0x10, flag-set 0x14, flag-clear 0x18, reload limit 0x1C, count 0x24. The control word holds the direction in [1:0], single-shot in bit 4, the source select in [17:16] and the divider code in [27:24]. Its other bits read 0. Command, flag-set, flag-clear and unmapped offsets read 0.
- R3: With direction 0, divider code n and source 0, a start command clears the divider phase. The count then rises by one on every 2^n-th clock edge, the first step landing 2^n edges after the edge that took the start write.
- R4: With direction 1, the count falls by one per divided tick.
- R5: Counting up, a tick while the count equals the reload limit sets the count to 0 and sets flag bit 0 (overflow).
- R6: Counting down, a tick while the count is 0 loads the reload limit into the count and sets flag bit 1 (underflow).
- R7: With single-shot set (control bit 4), the timer stops on the same edge as the first wrap and holds the wrapped count until started again.
- R8: Command bit 1 stops the counter and the count then holds. If bits 0 and 1 are written together, stop wins.
- R9: A write to the count offset loads its low 16 bits at that edge, whether the timer is running or not. The count can be read at any time.
- R10: Ones written to flag-set set flags and ones written to flag-clear clear them, while zero bits leave flags unchanged. A wrap that sets a flag on the same edge as a clear of that flag leaves it set.
- R11: The interrupt output is high exactly when some flag is set whose enable-mask bit (same bit positions as the flags) is also set.
- R12: A nonzero source select in control [17:16] stops the count from advancing even while the timer is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle, 0 otherwise |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect on the rising edge that samples the strobe, while read data and the interrupt line follow the registers combinationally within the same cycle. The count first moves 2^n edges after the start edge, and a wrap flag appears on the same edge as the wrapped count. The bench drives every bus access at a falling edge and samples one nanosecond later. It counts the rising edges since the start write and predicts each count as the load value plus the number of elapsed divided ticks. The case where a wrap collides with a clear is arranged by issuing the clear on the exact edge the wrap lands.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    localparam int DATA_W  = 32;
    localparam int CODE_W  = 4;
    localparam int PCNT_W  = (1 << CODE_W) - 1;
    localparam int FLG_N   = 2;
    localparam int FLG_OVF = 0;
    localparam int FLG_UNF = 1;

    localparam int IDX_CTL  = 0;
    localparam int IDX_CMD  = 1;
    localparam int IDX_IEN  = 3;
    localparam int IDX_FLG  = 4;
    localparam int IDX_FSET = 5;
    localparam int IDX_FCLR = 6;
    localparam int IDX_TOP  = 7;
    localparam int IDX_CNT  = 9;

    typedef enum logic [1:0] {
        DIR_UP   = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_RSV2 = 2'd2,
        DIR_RSV3 = 2'd3
    } dir_e;

    typedef struct packed {
        logic [CODE_W-1:0] presc;
        logic [1:0]        src;
        logic              one_shot;
        dir_e              dir;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [DATA_W-1:0] w);
        ctl_t c;
        c.presc    = w[27:24];
        c.src      = w[17:16];
        c.one_shot = w[4];
        c.dir      = dir_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[27:24] = c.presc;
        w[17:16] = c.src;
        w[4]     = c.one_shot;
        w[1:0]   = c.dir;
        return w;
    endfunction

    function automatic logic [PCNT_W-1:0] tick_mask(input logic [CODE_W-1:0] code);
        return (PCNT_W'(1) << code) - PCNT_W'(1);
    endfunction

endpackage

// File: rtl/updn_timer_presc.sv
module updn_timer_presc
    import updn_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic              src_ok,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PCNT_W-1:0] phase_q;
    logic [PCNT_W-1:0] mask;

    assign mask = tick_mask(code);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + PCNT_W'(1);
        end
    end

    assign tick = run && src_ok && ((phase_q & mask) == mask);

endmodule

// File: rtl/updn_timer_cnt.sv
module updn_timer_cnt
    import updn_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] top,
    input  logic             start,
    input  logic             stop,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic [FLG_N-1:0] hw_set
);

    logic             down;
    logic             at_top;
    logic             at_zero;
    logic             ovf_ev;
    logic             unf_ev;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             run_q;

    assign down    = (ctl.dir == DIR_DOWN);
    assign at_top  = (cnt_q == top);
    assign at_zero = (cnt_q == '0);
    assign ovf_ev  = tick && !down && at_top && !ld;
    assign unf_ev  = tick && down && at_zero && !ld;

    always_comb begin
        cnt_d = cnt_q;
        if (ld) begin
            cnt_d = ld_val;
        end else if (tick) begin
            if (down) begin
                cnt_d = at_zero ? top : cnt_q - CNT_W'(1);
            end else begin
                cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (stop) begin
                run_q <= 1'b0;
            end else if (start) begin
                run_q <= 1'b1;
            end else if (ctl.one_shot && (ovf_ev || unf_ev)) begin
                run_q <= 1'b0;
            end
        end
    end

    always_comb begin
        hw_set          = '0;
        hw_set[FLG_OVF] = ovf_ev;
        hw_set[FLG_UNF] = unf_ev;
    end

    assign cnt     = cnt_q;
    assign running = run_q;

endmodule

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [FLG_N-1:0]  hw_set,
    output ctl_t              ctl,
    output logic [FLG_N-1:0]  ien,
    output logic [FLG_N-1:0]  flags,
    output logic [CNT_W-1:0]  top,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_CTL  = WORD_W'(IDX_CTL);
    localparam logic [WORD_W-1:0] W_CMD  = WORD_W'(IDX_CMD);
    localparam logic [WORD_W-1:0] W_IEN  = WORD_W'(IDX_IEN);
    localparam logic [WORD_W-1:0] W_FLG  = WORD_W'(IDX_FLG);
    localparam logic [WORD_W-1:0] W_FSET = WORD_W'(IDX_FSET);
    localparam logic [WORD_W-1:0] W_FCLR = WORD_W'(IDX_FCLR);
    localparam logic [WORD_W-1:0] W_TOP  = WORD_W'(IDX_TOP);
    localparam logic [WORD_W-1:0] W_CNT  = WORD_W'(IDX_CNT);

    logic [WORD_W-1:0] word;
    logic [FLG_N-1:0]  sw_set;
    logic [FLG_N-1:0]  sw_clr;
    ctl_t              ctl_q;
    logic [FLG_N-1:0]  ien_q;
    logic [FLG_N-1:0]  flg_q;
    logic [CNT_W-1:0]  top_q;
    logic              unused_bits;

    assign word        = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata};

    assign sw_set     = (wr && word == W_FSET) ? wdata[FLG_N-1:0] : '0;
    assign sw_clr     = (wr && word == W_FCLR) ? wdata[FLG_N-1:0] : '0;
    assign cmd_start  = wr && (word == W_CMD) && wdata[0];
    assign cmd_stop   = wr && (word == W_CMD) && wdata[1];
    assign cnt_ld     = wr && (word == W_CNT);
    assign cnt_ld_val = wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= ctl_from_word('0);
            ien_q <= '0;
            flg_q <= '0;
            top_q <= '1;
        end else begin
            if (wr && word == W_CTL) begin
                ctl_q <= ctl_from_word(wdata);
            end
            if (wr && word == W_IEN) begin
                ien_q <= wdata[FLG_N-1:0];
            end
            if (wr && word == W_TOP) begin
                top_q <= wdata[CNT_W-1:0];
            end
            flg_q <= (flg_q & ~sw_clr) | sw_set | hw_set;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (word)
                W_CTL:   rdata = ctl_to_word(ctl_q);
                W_IEN:   rdata[FLG_N-1:0] = ien_q;
                W_FLG:   rdata[FLG_N-1:0] = flg_q;
                W_TOP:   rdata[CNT_W-1:0] = top_q;
                W_CNT:   rdata[CNT_W-1:0] = cnt;
                default: rdata = '0;
            endcase
        end
    end

    assign ctl   = ctl_q;
    assign ien   = ien_q;
    assign flags = flg_q;
    assign top   = top_q;

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctl_t             ctl;
    logic [FLG_N-1:0] ien;
    logic [FLG_N-1:0] flags;
    logic [FLG_N-1:0] hw_set;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_ld_val;
    logic             cmd_start;
    logic             cmd_stop;
    logic             cnt_ld;
    logic             running;
    logic             tick;
    logic             cnt_down;

    updn_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .cnt        (cnt),
        .hw_set     (hw_set),
        .ctl        (ctl),
        .ien        (ien),
        .flags      (flags),
        .top        (top_val),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val)
    );

    updn_timer_presc presc_i (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (cmd_start),
        .src_ok  (ctl.src == 2'd0),
        .code    (ctl.presc),
        .tick    (tick)
    );

    updn_timer_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ctl     (ctl),
        .top     (top_val),
        .start   (cmd_start),
        .stop    (cmd_stop),
        .ld      (cnt_ld),
        .ld_val  (cnt_ld_val),
        .cnt     (cnt),
        .running (running),
        .hw_set  (hw_set)
    );

    assign cnt_down = (ctl.dir == DIR_DOWN);
    assign irq      = |(flags & ien);

endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             running,
    input logic             one_shot,
    input logic             down,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] top,
    input logic [1:0]       flags,
    input logic [1:0]       ien,
    input logic [1:0]       hw_set,
    input logic             cnt_ld,
    input logic [CNT_W-1:0] cnt_ld_val,
    input logic             cmd_start,
    input logic             irq
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!running && cnt == '0 && flags == '0 && top == '1 && !irq));

    a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !down && cnt != top && !cnt_ld) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r5_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !down && cnt == top && !cnt_ld) |=> (cnt == '0 && flags[0]));

    a_r6_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && down && cnt == '0 && !cnt_ld) |=> (cnt == $past(top) && flags[1]));

    a_r7_one_shot_halt: assert property (@(posedge clk) disable iff (rst)
        (one_shot && (|hw_set) && !cmd_start) |=> !running);

    a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd_start && !cnt_ld) |=> $stable(cnt));

    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        cnt_ld |=> (cnt == $past(cnt_ld_val)));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    a_r11_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((|flags) && (|ien)));

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> !irq);

endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .running    (running),
    .one_shot   (ctl.one_shot),
    .down       (cnt_down),
    .cnt        (cnt),
    .top        (top_val),
    .flags      (flags),
    .ien        (ien),
    .hw_set     (hw_set),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .cmd_start  (cmd_start),
    .irq        (irq)
);

// File: tb/updn_timer_tb_top.sv
`timescale 1ns/1ps
module updn_timer_tb_top;

    localparam logic [7:0] A_CTL  = 8'h00;
    localparam logic [7:0] A_CMD  = 8'h04;
    localparam logic [7:0] A_IEN  = 8'h0C;
    localparam logic [7:0] A_FLG  = 8'h10;
    localparam logic [7:0] A_FSET = 8'h14;
    localparam logic [7:0] A_FCLR = 8'h18;
    localparam logic [7:0] A_TOP  = 8'h1C;
    localparam logic [7:0] A_CNT  = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    updn_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctl", A_CTL, 32'h0);
        rd_chk("R1 ien", A_IEN, 32'h0);
        rd_chk("R1 flags", A_FLG, 32'h0);
        rd_chk("R1 top", A_TOP, 32'h0000_FFFF);
        rd_chk("R1 cnt", A_CNT, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        wait_edges(20);
        rd_chk("R1 stopped after reset", A_CNT, 32'h0);
    endtask

    task automatic t_regmap;
        wr(A_CTL, 32'hFFFF_FFFF);
        rd_chk("R2 ctl fields", A_CTL, 32'h0F03_0013);
        wr(A_CTL, 32'h0);
        wr(A_IEN, 32'hFFFF_FFFF);
        rd_chk("R2 ien width", A_IEN, 32'h3);
        wr(A_IEN, 32'h0);
        rd_chk("R2 cmd reads zero", A_CMD, 32'h0);
        rd_chk("R2 fset reads zero", A_FSET, 32'h0);
        rd_chk("R2 unmapped 0x08", 8'h08, 32'h0);
        rd_chk("R2 unmapped 0x20", 8'h20, 32'h0);
        wr(A_TOP, 32'h1234_ABCD);
        rd_chk("R2 top width", A_TOP, 32'h0000_ABCD);
        wr(A_TOP, 32'hFFFF);
    endtask

    task automatic t_up_div1;
        wr(A_CTL, 32'h0);
        wr(A_CNT, 32'd5);
        wr(A_CMD, 32'h1);
        wait_edges(4);
        rd_chk("R3 up by one per edge", A_CNT, 32'd9);
        wr(A_CMD, 32'h2);
        rd_chk("R8 stop takes effect", A_CNT, 32'd10);
        wait_edges(3);
        rd_chk("R8 held after stop", A_CNT, 32'd10);
    endtask

    task automatic t_div4;
        wr(A_CTL, 32'h0200_0000);
        wr(A_CNT, 32'd0);
        wr(A_CMD, 32'h1);
        wait_edges(3);
        rd_chk("R3 div4 no step before 4 edges", A_CNT, 32'd0);
        wait_edges(1);
        rd_chk("R3 div4 first step", A_CNT, 32'd1);
        wait_edges(4);
        rd_chk("R3 div4 second step", A_CNT, 32'd2);
        wait_edges(2);
        wr(A_CMD, 32'h2);
        rd_chk("R8 div4 stopped", A_CNT, 32'd2);
        wr(A_CMD, 32'h1);
        wait_edges(3);
        rd_chk("R3 restart clears phase", A_CNT, 32'd2);
        wait_edges(1);
        rd_chk("R3 restart first step", A_CNT, 32'd3);
        wr(A_CMD, 32'h2);
    endtask

    task automatic t_down_wrap;
        wr(A_FCLR, 32'h3);
        wr(A_CTL, 32'h1);
        wr(A_TOP, 32'd9);
        wr(A_CNT, 32'd3);
        wr(A_CMD, 32'h1);
        wait_edges(2);
        rd_chk("R4 down count", A_CNT, 32'd1);
        rd_chk("R6 no flag before wrap", A_FLG, 32'h0);
        wait_edges(1);
        rd_chk("R4 reaches zero", A_CNT, 32'd0);
        wait_edges(1);
        rd_chk("R6 reload from limit", A_CNT, 32'd9);
        rd_chk("R6 underflow flag", A_FLG, 32'h2);
        wr(A_CMD, 32'h2);
        wr(A_FCLR, 32'h3);
    endtask

    task automatic t_up_wrap;
        wr(A_CTL, 32'h0);
        wr(A_TOP, 32'd7);
        wr(A_CNT, 32'd5);
        wr(A_CMD, 32'h1);
        wait_edges(2);
        rd_chk("R5 at limit", A_CNT, 32'd7);
        rd_chk("R5 no flag yet", A_FLG, 32'h0);
        wait_edges(1);
        rd_chk("R5 wraps to zero", A_CNT, 32'd0);
        rd_chk("R5 overflow flag", A_FLG, 32'h1);
        wr(A_CMD, 32'h2);
        wr(A_FCLR, 32'h3);
    endtask

    task automatic t_one_shot;
        wr(A_CTL, 32'h11);
        wr(A_TOP, 32'd4);
        wr(A_CNT, 32'd1);
        wr(A_CMD, 32'h1);
        wait_edges(2);
        rd_chk("R7 wrapped value", A_CNT, 32'd4);
        rd_chk("R7 underflow flag", A_FLG, 32'h2);
        wait_edges(6);
        rd_chk("R7 halted after wrap", A_CNT, 32'd4);
        wr(A_CMD, 32'h1);
        rd_chk("R7 restart runs again", A_CNT, 32'd4);
        wait_edges(1);
        rd_chk("R7 restart step", A_CNT, 32'd3);
        wr(A_CMD, 32'h2);
        wr(A_FCLR, 32'h3);
    endtask

    task automatic t_flag_alias;
        wr(A_FSET, 32'h1);
        rd_chk("R10 set bit0", A_FLG, 32'h1);
        wr(A_FSET, 32'h2);
        rd_chk("R10 zero bits untouched by set", A_FLG, 32'h3);
        wr(A_FCLR, 32'h1);
        rd_chk("R10 clear bit0 only", A_FLG, 32'h2);
        wr(A_FCLR, 32'h2);
        rd_chk("R10 all clear", A_FLG, 32'h0);
    endtask

    task automatic t_irq;
        wr(A_IEN, 32'h2);
        wr(A_FSET, 32'h1);
        check("R11 masked flag", {31'b0, irq}, 32'h0);
        wr(A_FSET, 32'h2);
        check("R11 enabled flag", {31'b0, irq}, 32'h1);
        wr(A_FCLR, 32'h2);
        check("R11 cleared", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h3);
        check("R11 enable exposes pending", {31'b0, irq}, 32'h1);
        wr(A_FCLR, 32'h1);
        check("R11 all quiet", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_set_wins;
        wr(A_CTL, 32'h10);
        wr(A_TOP, 32'd3);
        wr(A_CNT, 32'd3);
        wr(A_FCLR, 32'h3);
        wr(A_CMD, 32'h1);
        wr(A_FCLR, 32'h1);
        rd_chk("R10 wrap beats clear", A_FLG, 32'h1);
        rd_chk("R5 wrap with clear", A_CNT, 32'd0);
        wr(A_FCLR, 32'h1);
        rd_chk("R10 later clear", A_FLG, 32'h0);
    endtask

    task automatic t_stop_wins;
        wr(A_CTL, 32'h0);
        wr(A_TOP, 32'hFFFF);
        wr(A_CNT, 32'd10);
        wr(A_CMD, 32'h3);
        wait_edges(5);
        rd_chk("R8 stop beats start", A_CNT, 32'd10);
    endtask

    task automatic t_load_running;
        wr(A_CMD, 32'h1);
        wait_edges(2);
        wr(A_CNT, 32'h100);
        rd_chk("R9 load while running", A_CNT, 32'h100);
        wait_edges(1);
        rd_chk("R9 continues from load", A_CNT, 32'h101);
        wr(A_CMD, 32'h2);
    endtask

    task automatic t_src_sel;
        wr(A_CTL, 32'h0001_0000);
        wr(A_CNT, 32'd0);
        wr(A_CMD, 32'h1);
        wait_edges(5);
        rd_chk("R12 other source frozen", A_CNT, 32'd0);
        wr(A_CMD, 32'h2);
        wr(A_CTL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_up_div1();
        t_div4();
        t_down_wrap();
        t_up_wrap();
        t_one_shot();
        t_flag_alias();
        t_irq();
        t_set_wins();
        t_stop_wins();
        t_load_running();
        t_src_sel();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule